// File: doc/BRIEF.md
# Board Reset Sequencer with Cause Logging

This block orders the reset of a processor board. Four events can start a sequence: release of the power-on reset, a reset pushbutton, a JTAG reset request and a single-cycle software reconfiguration pulse. Each sequence follows the same fixed steps. A cause-specific start step loads the switch-derived configuration register with its default. A sampling step copies the configuration switches into that register. An optional remote-wait step holds until a permission input arrives. A hold step keeps the reset outputs asserted for a programmable number of clocks. A final step waits until every level request has dropped. The sequencer then sits in a complete state and watches for the next event.

The current step is shown as a 4-bit state code. One status bit reports "system in reset" and another reports "waiting for remote permission". An 8-bit reason register holds the cause of the latest sequence and the cause of the sequence before it. The reset outputs are split into device groups. Each group has a force bit and a mask bit that act on its output independently of the sequence.

Top module: `brd_rst_seq`

## Requirements
- R1: While rst_n is low, seq_code is 0x1 (power-on start), in_reset is 1, rmt_waiting is 0, every grp_rst_n bit is 0, reason is 0x01 and cfg_q equals CFG_DEFAULT. After release the power-on sequence runs without any other request.
- R2: A sequence visits its start code, then 0x2 (sample), then 0x3 (remote wait, only when rmt_hold_en is 1), then 0x4 (hold), then 0xF (wait for clear), and finally 0x0 (complete). Each start code and 0x2 last exactly one cycle. in_reset is 1 in every code except 0x0.
- R3: The cycle after a start code, cfg_q holds CFG_DEFAULT. While the code is 0x2, sw_in is captured into cfg_q, and it is visible from the next cycle. Changes on sw_in at any other time leave cfg_q unchanged.
- R4: Code 0x4 lasts max(min_hold, 1) cycles and is always followed by 0xF.
- R5: btn_req and jtag_req are levels, each passed through a two-stage synchronizer. When one of them is seen in code 0x0, the next code is 0xD (button, cause 2) or 0xC (JTAG, cause 3).
- R6: A reconf_go pulse sampled in code 0x0 with no synchronized level request gives code 0xE (cause 4) on the next cycle. A reconf_go pulse in any other code has no effect.
- R7: Code 0xF is held while the synchronized btn_req or jtag_req is 1.
- R8: Requests seen in the same cycle of code 0x0 are ranked: button first, then JTAG, then reconfiguration.
- R9: reason[3:0] is the current cause and reason[7:4] the previous cause. The cause codes are 0 for none, 1 for power-on, 2 for button, 3 for JTAG and 4 for reconfiguration. When a sequence starts, the old current cause moves to reason[7:4] and the new cause is written to reason[3:0].
- R10: rmt_waiting is 1 exactly in code 0x3. The code leaves 0x3 for 0x4 once rmt_permit, through a two-stage synchronizer, reads 1.
- R11: grp_force[g] = 1 drives grp_rst_n[g] low on the next cycle, whatever the state or mask.
- R12: grp_rst_n is registered. Without force, grp_rst_n[g] is the inverse of the previous cycle's in_reset, except that a group with grp_mask[g] = 1 stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| btn_req | input | 1 | Reset pushbutton level, asynchronous |
| jtag_req | input | 1 | JTAG reset request level, asynchronous |
| reconf_go | input | 1 | Software reconfiguration pulse, synchronous |
| rmt_hold_en | input | 1 | Insert the remote-wait step into sequences |
| rmt_permit | input | 1 | Remote permission level, asynchronous |
| min_hold | input | CNT_W | Minimum cycles of the hold step |
| sw_in | input | SW_W | Configuration switch levels |
| grp_force | input | NGRP | Per-group reset force |
| grp_mask | input | NGRP | Per-group reset mask |
| grp_rst_n | output | NGRP | Per-group active-low reset outputs |
| cfg_q | output | SW_W | Switch-derived configuration register |
| seq_code | output | 4 | Current state code |
| in_reset | output | 1 | System is in reset |
| rmt_waiting | output | 1 | Waiting in the remote-wait step |
| reason | output | 8 | {previous cause, current cause} |

## Verification
Two collisions can occur in the complete state. A synchronized pushbutton level and a reconfiguration pulse can arrive in the same cycle. A pushbutton and a JTAG request can also rise together. For the first case the bench drives the button, counts the two synchronizer stages and places the reconf_go pulse on exactly the edge where the synchronized level first appears. It then expects the button start code 0xD and cause 2 on the next cycle, with the old cause shifted into the previous nibble, and no reconfiguration start afterwards. A reconf_go pulse is also sent while code 0xF is held, and the bench confirms that it leaves both the code and the reason register unchanged.

// File: rtl/brd_rst_pkg.sv
package brd_rst_pkg;

  typedef enum logic [3:0] {
    ST_DONE     = 4'h0,
    ST_PWRON    = 4'h1,
    ST_SAMPLE   = 4'h2,
    ST_RMT_WAIT = 4'h3,
    ST_HOLD     = 4'h4,
    ST_JTAG     = 4'hC,
    ST_BUTTON   = 4'hD,
    ST_RECONFIG = 4'hE,
    ST_POST     = 4'hF
  } seq_state_e;

  typedef enum logic [3:0] {
    CAUSE_NONE     = 4'h0,
    CAUSE_PWRON    = 4'h1,
    CAUSE_BUTTON   = 4'h2,
    CAUSE_JTAG     = 4'h3,
    CAUSE_RECONFIG = 4'h4
  } cause_e;

  typedef struct packed {
    cause_e prev;
    cause_e cur;
  } reason_t;

  function automatic logic is_start(input seq_state_e s);
    return (s == ST_PWRON) || (s == ST_JTAG) || (s == ST_BUTTON) || (s == ST_RECONFIG);
  endfunction

endpackage

// File: rtl/brd_rst_sync.sv
module brd_rst_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < NS; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[NS-1];
endmodule

// File: rtl/brd_rst_cause_pick.sv
module brd_rst_cause_pick
  import brd_rst_pkg::*;
(
  input  logic       btn_s,
  input  logic       jtag_s,
  input  logic       go,
  output logic       hit,
  output cause_e     cause,
  output seq_state_e start_st
);
  always_comb begin
    hit      = 1'b1;
    cause    = CAUSE_NONE;
    start_st = ST_DONE;
    if (btn_s) begin
      cause    = CAUSE_BUTTON;
      start_st = ST_BUTTON;
    end else if (jtag_s) begin
      cause    = CAUSE_JTAG;
      start_st = ST_JTAG;
    end else if (go) begin
      cause    = CAUSE_RECONFIG;
      start_st = ST_RECONFIG;
    end else begin
      hit      = 1'b0;
    end
  end
endmodule

// File: rtl/brd_rst_hold_timer.sv
module brd_rst_hold_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] min_cnt,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign expired = cnt_inc >= {1'b0, min_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/brd_rst_grp_gate.sv
module brd_rst_grp_gate #(
  parameter int NGRP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seq_act,
  input  logic [NGRP-1:0] force_i,
  input  logic [NGRP-1:0] mask_i,
  output logic [NGRP-1:0] rst_n_o
);
  logic [NGRP-1:0] assert_d;

  assign assert_d = ({NGRP{seq_act}} & ~mask_i) | force_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_n_o <= '0;
    end else begin
      rst_n_o <= ~assert_d;
    end
  end
endmodule

// File: rtl/brd_rst_seq.sv
module brd_rst_seq
  import brd_rst_pkg::*;
#(
  parameter int          NGRP        = 4,
  parameter int          SW_W        = 8,
  parameter int          CNT_W       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CFG_DEFAULT = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_req,
  input  logic             jtag_req,
  input  logic             reconf_go,
  input  logic             rmt_hold_en,
  input  logic             rmt_permit,
  input  logic [CNT_W-1:0] min_hold,
  input  logic [SW_W-1:0]  sw_in,
  input  logic [NGRP-1:0]  grp_force,
  input  logic [NGRP-1:0]  grp_mask,
  output logic [NGRP-1:0]  grp_rst_n,
  output logic [SW_W-1:0]  cfg_q,
  output logic [3:0]       seq_code,
  output logic             in_reset,
  output logic             rmt_waiting,
  output logic [7:0]       reason
);
  localparam int NSYNC = 3;
  localparam logic [SW_W-1:0] CFG_DEF_W = SW_W'(CFG_DEFAULT);

  seq_state_e state_q, state_d;
  reason_t    reason_q;
  logic [NSYNC-1:0] async_raw, async_s;
  logic btn_s, jtag_s, permit_s;
  logic pick_hit;
  cause_e pick_cause;
  seq_state_e pick_start;
  logic hold_done;
  logic seq_act;
  logic reason_en, cfg_en;
  logic [SW_W-1:0] cfg_d;

  assign async_raw = {rmt_permit, jtag_req, btn_req};

  brd_rst_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (async_raw),
    .q     (async_s)
  );

  assign btn_s    = async_s[0];
  assign jtag_s   = async_s[1];
  assign permit_s = async_s[2];

  brd_rst_cause_pick pick_i (
    .btn_s    (btn_s),
    .jtag_s   (jtag_s),
    .go       (reconf_go),
    .hit      (pick_hit),
    .cause    (pick_cause),
    .start_st (pick_start)
  );

  brd_rst_hold_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_HOLD),
    .min_cnt (min_hold),
    .expired (hold_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DONE:     if (pick_hit) state_d = pick_start;
      ST_PWRON,
      ST_JTAG,
      ST_BUTTON,
      ST_RECONFIG: state_d = ST_SAMPLE;
      ST_SAMPLE:   state_d = rmt_hold_en ? ST_RMT_WAIT : ST_HOLD;
      ST_RMT_WAIT: if (permit_s) state_d = ST_HOLD;
      ST_HOLD:     if (hold_done) state_d = ST_POST;
      ST_POST:     if (!btn_s && !jtag_s) state_d = ST_DONE;
      default:     state_d = ST_PWRON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRON;
    end else begin
      state_q <= state_d;
    end
  end

  // cause log: shift current into previous on each new start
  assign reason_en = (state_q == ST_DONE) && pick_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reason_q <= '{prev: CAUSE_NONE, cur: CAUSE_PWRON};
    end else if (reason_en) begin
      reason_q <= '{prev: reason_q.cur, cur: pick_cause};
    end
  end

  // switch-derived register: default at start, switch image at sample
  always_comb begin
    cfg_en = 1'b0;
    cfg_d  = CFG_DEF_W;
    if (is_start(state_q)) begin
      cfg_en = 1'b1;
      cfg_d  = CFG_DEF_W;
    end else if (state_q == ST_SAMPLE) begin
      cfg_en = 1'b1;
      cfg_d  = sw_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_DEF_W;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign seq_act = (state_q != ST_DONE);

  brd_rst_grp_gate #(.NGRP(NGRP)) gate_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq_act (seq_act),
    .force_i (grp_force),
    .mask_i  (grp_mask),
    .rst_n_o (grp_rst_n)
  );

  assign seq_code    = state_q;
  assign in_reset    = seq_act;
  assign rmt_waiting = (state_q == ST_RMT_WAIT);
  assign reason      = reason_q;
endmodule

// File: rtl/brd_rst_seq_chk.sv
module brd_rst_seq_chk #(
  parameter int NGRP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      seq_code,
  input logic            in_reset,
  input logic            rmt_waiting,
  input logic [7:0]      reason,
  input logic [NGRP-1:0] grp_rst_n,
  input logic [NGRP-1:0] grp_force,
  input logic [NGRP-1:0] grp_mask,
  input logic            reconf_go,
  input logic            btn_s,
  input logic            jtag_s,
  input logic            permit_s
);
  assert_stay_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 4'hF && (btn_s || jtag_s)) |=> seq_code == 4'hF);

  assert_go_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 4'h0 && reconf_go && !btn_s && !jtag_s) |=> seq_code == 4'hE);

  assert_prev_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_code == 4'h0 && (btn_s || jtag_s || reconf_go)) |=> reason[7:4] == $past(reason[3:0]));

  assert_rmt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_waiting && !permit_s) |=> rmt_waiting);

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset) |-> $past(seq_code) == 4'hF);

  assert_hold_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_code) == 4'h4 && seq_code != 4'h4) |-> seq_code == 4'hF);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assert_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
      grp_force[g] |=> !grp_rst_n[g]);
    assert_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_force[g] && grp_mask[g]) |=> grp_rst_n[g]);
  end
endmodule

bind brd_rst_seq brd_rst_seq_chk #(.NGRP(NGRP)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .seq_code    (seq_code),
  .in_reset    (in_reset),
  .rmt_waiting (rmt_waiting),
  .reason      (reason),
  .grp_rst_n   (grp_rst_n),
  .grp_force   (grp_force),
  .grp_mask    (grp_mask),
  .reconf_go   (reconf_go),
  .btn_s       (btn_s),
  .jtag_s      (jtag_s),
  .permit_s    (permit_s)
);

// File: tb/brd_rst_seq_tb_top.sv
module brd_rst_seq_tb_top;
  localparam int NGRP = 4;
  localparam int SW_W = 8;
  localparam int CNT_W = 8;
  localparam logic [7:0] CFG_DEF = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic btn_req, jtag_req, reconf_go, rmt_hold_en, rmt_permit;
  logic [CNT_W-1:0] min_hold;
  logic [SW_W-1:0]  sw_in;
  logic [NGRP-1:0]  grp_force, grp_mask, grp_rst_n;
  logic [SW_W-1:0]  cfg_q;
  logic [3:0]       seq_code;
  logic             in_reset, rmt_waiting;
  logic [7:0]       reason;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [3:0] exp_cur;

  always #10 clk = ~clk;

  brd_rst_seq #(.NGRP(NGRP), .SW_W(SW_W), .CNT_W(CNT_W), .CFG_DEFAULT(CFG_DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_req(btn_req), .jtag_req(jtag_req),
    .reconf_go(reconf_go), .rmt_hold_en(rmt_hold_en), .rmt_permit(rmt_permit),
    .min_hold(min_hold), .sw_in(sw_in), .grp_force(grp_force), .grp_mask(grp_mask),
    .grp_rst_n(grp_rst_n), .cfg_q(cfg_q), .seq_code(seq_code), .in_reset(in_reset),
    .rmt_waiting(rmt_waiting), .reason(reason)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] start_code(input int kind);
    case (kind)
      1:       return 4'hC;
      2:       return 4'hE;
      default: return 4'hD;
    endcase
  endfunction

  function automatic logic [3:0] cause_code(input int kind);
    case (kind)
      1:       return 4'h3;
      2:       return 4'h4;
      default: return 4'h2;
    endcase
  endfunction

  function automatic int hold_len(input int unsigned m);
    return (m == 0) ? 1 : int'(m);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_code(input logic [3:0] code, input int lim, input string req);
    int n = 0;
    while (seq_code !== code && n < lim) begin
      tick();
      n++;
    end
    check(seq_code === code, req, seq_code, code);
  endtask

  // kind: 0 button, 1 jtag, 2 reconfig, 3 button+reconfig same cycle, 4 button+jtag
  task automatic run_event(input int kind, input int unsigned minh, input bit rmt,
                           input logic [NGRP-1:0] mask, input logic [SW_W-1:0] swv);
    logic [7:0] exp_reason;
    int cnt;
    bit level = (kind != 2);
    min_hold = CNT_W'(minh);
    rmt_hold_en = rmt;
    sw_in = swv;
    grp_mask = mask;
    exp_reason = {exp_cur, cause_code(kind)};
    case (kind)
      2: begin
        reconf_go = 1'b1; tick(); reconf_go = 1'b0;
        check(seq_code === 4'hE, "R6 reconfig start", seq_code, 4'hE);
      end
      3: begin
        btn_req = 1'b1; tick(); tick();
        reconf_go = 1'b1; tick(); reconf_go = 1'b0;
        check(seq_code === 4'hD, "R8 button beats reconfig", seq_code, 4'hD);
      end
      4: begin
        btn_req = 1'b1; jtag_req = 1'b1;
        wait_code(4'hD, 6, "R8 button beats jtag");
      end
      1: begin
        jtag_req = 1'b1;
        wait_code(4'hC, 6, "R5 jtag start");
      end
      default: begin
        btn_req = 1'b1;
        wait_code(4'hD, 6, "R5 button start");
      end
    endcase
    check(reason === exp_reason, "R9 reason shift", reason, exp_reason);
    exp_cur = cause_code(kind);
    tick();
    check(seq_code === 4'h2, "R2 sample step", seq_code, 4'h2);
    check(cfg_q === CFG_DEF, "R3 default at start", cfg_q, CFG_DEF);
    tick();
    if (rmt) begin
      check(seq_code === 4'h3 && rmt_waiting === 1'b1, "R10 remote wait", {seq_code, 3'b0, rmt_waiting}, 8'h31);
      repeat (2 + $urandom % 5) begin
        tick();
        check(seq_code === 4'h3, "R10 held without permit", seq_code, 4'h3);
      end
      rmt_permit = 1'b1;
      wait_code(4'h4, 6, "R10 permit proceeds");
    end else begin
      check(seq_code === 4'h4, "R2 hold after sample", seq_code, 4'h4);
    end
    check(cfg_q === swv, "R3 switch sampled", cfg_q, swv);
    check(grp_rst_n === mask, "R12 mask during reset", grp_rst_n, mask);
    check(in_reset === 1'b1, "R2 in reset", in_reset, 1);
    cnt = 1;
    tick();
    while (seq_code === 4'h4 && cnt < 300) begin
      cnt++;
      tick();
    end
    check(cnt == hold_len(minh), "R4 hold length", cnt, hold_len(minh));
    check(seq_code === 4'hF, "R4 wait-clear after hold", seq_code, 4'hF);
    rmt_permit = 1'b0;
    if (level) begin
      reconf_go = 1'b1; tick(); reconf_go = 1'b0;
      repeat (3) begin
        check(seq_code === 4'hF, "R7 held while request", seq_code, 4'hF);
        tick();
      end
      btn_req = 1'b0; jtag_req = 1'b0;
      wait_code(4'h0, 6, "R2 complete after clear");
    end else begin
      tick();
      check(seq_code === 4'h0, "R2 complete", seq_code, 4'h0);
    end
    check(in_reset === 1'b0, "R2 out of reset", in_reset, 0);
    check(grp_rst_n === mask, "R12 registered release", grp_rst_n, mask);
    tick();
    check(grp_rst_n === {NGRP{1'b1}}, "R12 released", grp_rst_n, {NGRP{1'b1}});
    sw_in = ~swv;
    repeat (3) tick();
    check(cfg_q === swv, "R3 switches ignored when idle", cfg_q, swv);
    check(seq_code === 4'h0, "R6 ignored pulse no restart", seq_code, 4'h0);
    check(reason === {exp_reason[7:4], exp_cur}, "R6 reason unchanged", reason, {exp_reason[7:4], exp_cur});
    grp_mask = '0;
  endtask

  initial begin
    void'($urandom(32'd4177));
    rst_n = 1'b0;
    btn_req = 0; jtag_req = 0; reconf_go = 0; rmt_hold_en = 0; rmt_permit = 0;
    min_hold = 8'd3; sw_in = 8'h3C; grp_force = '0; grp_mask = '0;
    repeat (3) tick();
    check(seq_code === 4'h1, "R1 reset code", seq_code, 4'h1);
    check(in_reset === 1'b1 && rmt_waiting === 1'b0, "R1 status", {in_reset, rmt_waiting}, 2'b10);
    check(grp_rst_n === '0, "R1 outputs asserted", grp_rst_n, 0);
    check(reason === 8'h01, "R1 reason", reason, 8'h01);
    check(cfg_q === CFG_DEF, "R1 cfg default", cfg_q, CFG_DEF);
    rst_n = 1'b1;
    tick();
    check(seq_code === 4'h2, "R2 power-on sample", seq_code, 4'h2);
    for (int i = 0; i < 3; i++) begin
      tick();
      check(seq_code === 4'h4, "R4 power-on hold", seq_code, 4'h4);
    end
    check(cfg_q === 8'h3C, "R3 power-on switches", cfg_q, 8'h3C);
    tick();
    check(seq_code === 4'hF, "R2 power-on wait-clear", seq_code, 4'hF);
    tick();
    check(seq_code === 4'h0, "R2 power-on complete", seq_code, 4'h0);
    exp_cur = 4'h1;
    repeat (2) tick();

    grp_mask = 4'hF; grp_force = 4'b0101;
    tick();
    check(grp_rst_n === 4'b1010, "R11 force in idle", grp_rst_n, 4'b1010);
    check(seq_code === 4'h0, "R11 force starts nothing", seq_code, 4'h0);
    grp_force = '0; grp_mask = '0;
    tick();
    check(grp_rst_n === 4'hF, "R11 force removed", grp_rst_n, 4'hF);

    run_event(3, 2, 0, 4'b0000, 8'h11);
    run_event(2, 0, 1, 4'b0010, 8'h22);
    run_event(1, 1, 0, 4'b1000, 8'h33);
    run_event(4, 5, 1, 4'b0000, 8'h44);
    run_event(0, 0, 0, 4'b0110, 8'h55);
    for (int i = 0; i < 20; i++) begin
      run_event(int'($urandom % 5), $urandom % 7, 1'($urandom), NGRP'($urandom), SW_W'($urandom));
      repeat (1 + $urandom % 3) tick();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: act=%0h exp=%0h", seq_code, 4'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule